// File: doc/BRIEF.md
# Operand and Result Handshake Sequencer

This block steers one out-of-order computation slot through a single operation. It waits idle until an issue pulse arrives, then marks itself busy and asks a scoreboard-style arbiter for each of its three source operands through separate request/grant pairs. Every granted operand is captured in its own register and presented to a pipelined ALU. When the last outstanding operand has been captured, the block raises the ALU input valid and holds it until the ALU accepts. It then waits with the ALU output ready raised until a result appears, and captures that result in a holding register.

With a result held, the block asks for the write port. The request is held back while the active-low shadow input is low. On the cycle the write grant meets the write request, the held result is driven onto the result output without a register in between. On the next cycle the block is idle and can take a new issue. A kill input, valid in any cycle, drops the whole operation at the next clock edge.

Top module: `fu_hshake`

## Requirements
- R1: While reset is high and on the cycle after it, busy, every read request bit, the write request, ALU input valid and ALU output ready are low, and the result output is zero.
- R2: An issue pulse while idle, with kill low, makes busy high on the next cycle, with all three read request bits high on that same cycle.
- R3: When read request bit i and read grant bit i are both high at a clock edge, request bit i is low from the next cycle on. The other request bits are unaffected.
- R4: No read request bit is ever high while busy is low.
- R5: A grant on bit i captures source field i (src_i bits [16*i+15:16*i]) at the edge. The captured value appears in the same field of alu_opnd_o on the next cycle and stays there until the next capture on that port.
- R6: ALU input valid rises on the cycle after the last outstanding read grant. It stays high until a cycle in which the ALU input ready is also high, and is low from the next cycle on.
- R7: ALU output ready is high from the cycle after the input handshake until a cycle in which the ALU output valid is also high. At that edge the ALU result is captured into the holding register. An ALU output valid seen while output ready is low is ignored.
- R8: The write request stays low until a result has been captured. It rises on the first later edge at which shadow_n_i is high. While shadow_n_i is low, a low write request stays low, and once high it stays high until it is granted or killed.
- R9: In a cycle with both write request and write grant high, result_o equals the held ALU result in that same cycle, and it is zero in every other cycle. On the next cycle the write request and busy are low.
- R10: A kill at a clock edge makes busy, all read request bits, the write request, ALU input valid and ALU output ready low on the next cycle. An issue pulse in the same cycle as a kill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | One-cycle issue pulse, only while idle |
| kill_i | input | 1 | Abort of the current operation |
| shadow_n_i | input | 1 | Active low; low holds the write request back |
| busy_o | output | 1 | Slot occupied |
| rd_req_o | output | 3 | Read request, one bit per source operand |
| rd_gnt_i | input | 3 | Read grant, one bit per source operand |
| src_i | input | 48 | Source operand data, field i at bits [16*i+15:16*i] |
| alu_opnd_o | output | 48 | Captured operands to the ALU, same field layout |
| alu_in_valid_o | output | 1 | Operands offered to the ALU |
| alu_in_ready_i | input | 1 | ALU accepts operands |
| alu_res_i | input | 16 | ALU result |
| alu_out_valid_i | input | 1 | ALU result valid |
| alu_out_ready_o | output | 1 | Slot waiting for the ALU result |
| wr_req_o | output | 1 | Write-port request |
| wr_gnt_i | input | 1 | Write-port grant |
| result_o | output | 16 | Held result during a write grant, otherwise zero |

## Verification
On every cycle the assertions check the local temporal rules. Busy follows issue. No read request is raised while idle. A granted request bit drops. Held ALU valid stays up until it is accepted. The shadow input holds a low write request low. Retirement and kill each clear the slot. The bench's scenarios can show the end-to-end behaviour. They show that the right operand lands in the right field, and that the ALU result that was actually captured is the value driven during the write grant. They also show that a stale ALU valid arriving after a kill is ignored, and that an issue coinciding with a kill is dropped. Grant orders, shadow patterns and ALU latencies vary across operations.

// File: rtl/fu_hs_pkg.sv
package fu_hs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FETCH  = 2'd1,
    PH_EXEC   = 2'd2,
    PH_RETIRE = 2'd3
  } phase_t;

endpackage

// File: rtl/fu_opnd_bank.sv
module fu_opnd_bank #(
  parameter int NSRC = 3,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    load,
  input  logic [NSRC*DW-1:0] src,
  output logic [NSRC*DW-1:0] opnd
);

  // one independent capture register per source port
  for (genvar g = 0; g < NSRC; g++) begin : g_port
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (load[g])
        q <= src[g*DW +: DW];
    end
    assign opnd[g*DW +: DW] = q;
  end

endmodule

// File: rtl/fu_result_hold.sv
module fu_result_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] alu_res,
  input  logic          drive,
  output logic [DW-1:0] result
);

  logic [DW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)
      held <= '0;
    else if (capture)
      held <= alu_res;
  end

  // result goes out in the grant cycle itself
  assign result = drive ? held : '0;

endmodule

// File: rtl/fu_seq_ctl.sv
module fu_seq_ctl
  import fu_hs_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic            kill,
  input  logic            shadow_n,
  input  logic [NSRC-1:0] rd_gnt,
  input  logic            alu_in_ready,
  input  logic            alu_out_valid,
  input  logic            wr_gnt,
  output logic            busy,
  output logic [NSRC-1:0] rd_req,
  output logic [NSRC-1:0] load,
  output logic            alu_in_valid,
  output logic            alu_out_ready,
  output logic            capture,
  output logic            wr_req,
  output logic            drive
);

  localparam logic [NSRC-1:0] ALL_SRC = {NSRC{1'b1}};

  phase_t          phase;
  logic [NSRC-1:0] req_left;

  assign req_left = rd_req & ~rd_gnt;
  assign load     = rd_req & rd_gnt & {NSRC{~kill}};
  assign capture  = alu_out_ready & alu_out_valid & ~kill;
  assign drive    = wr_req & wr_gnt;
  assign busy     = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      phase         <= PH_IDLE;
      rd_req        <= '0;
      alu_in_valid  <= 1'b0;
      alu_out_ready <= 1'b0;
      wr_req        <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (issue) begin
            phase  <= PH_FETCH;
            rd_req <= ALL_SRC;
          end
        end
        PH_FETCH: begin
          rd_req <= req_left;
          if (req_left == '0) begin
            phase        <= PH_EXEC;
            alu_in_valid <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (alu_in_valid && alu_in_ready) begin
            alu_in_valid  <= 1'b0;
            alu_out_ready <= 1'b1;
          end else if (alu_out_ready && alu_out_valid) begin
            alu_out_ready <= 1'b0;
            phase         <= PH_RETIRE;
          end
        end
        PH_RETIRE: begin
          if (wr_req && wr_gnt) begin
            wr_req <= 1'b0;
            phase  <= PH_IDLE;
          end else if (shadow_n) begin
            wr_req <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fu_hshake.sv
module fu_hshake #(
  parameter int NSRC = 3,
  parameter int DW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_i,
  input  logic               kill_i,
  input  logic               shadow_n_i,
  output logic               busy_o,
  output logic [NSRC-1:0]    rd_req_o,
  input  logic [NSRC-1:0]    rd_gnt_i,
  input  logic [NSRC*DW-1:0] src_i,
  output logic [NSRC*DW-1:0] alu_opnd_o,
  output logic               alu_in_valid_o,
  input  logic               alu_in_ready_i,
  input  logic [DW-1:0]      alu_res_i,
  input  logic               alu_out_valid_i,
  output logic               alu_out_ready_o,
  output logic               wr_req_o,
  input  logic               wr_gnt_i,
  output logic [DW-1:0]      result_o
);

  logic [NSRC-1:0] load;
  logic            capture;
  logic            drive;

  fu_seq_ctl #(.NSRC(NSRC)) u_ctl (
    .clk           (clk),
    .rst           (rst),
    .issue         (issue_i),
    .kill          (kill_i),
    .shadow_n      (shadow_n_i),
    .rd_gnt        (rd_gnt_i),
    .alu_in_ready  (alu_in_ready_i),
    .alu_out_valid (alu_out_valid_i),
    .wr_gnt        (wr_gnt_i),
    .busy          (busy_o),
    .rd_req        (rd_req_o),
    .load          (load),
    .alu_in_valid  (alu_in_valid_o),
    .alu_out_ready (alu_out_ready_o),
    .capture       (capture),
    .wr_req        (wr_req_o),
    .drive         (drive)
  );

  fu_opnd_bank #(.NSRC(NSRC), .DW(DW)) u_opnd (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .src  (src_i),
    .opnd (alu_opnd_o)
  );

  fu_result_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .alu_res (alu_res_i),
    .drive   (drive),
    .result  (result_o)
  );

endmodule

// File: rtl/fu_hs_chk.sv
module fu_hs_chk #(
  parameter int NSRC = 3,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_i,
  input logic            kill_i,
  input logic            shadow_n_i,
  input logic            busy_o,
  input logic [NSRC-1:0] rd_req_o,
  input logic [NSRC-1:0] rd_gnt_i,
  input logic            alu_in_valid_o,
  input logic            alu_in_ready_i,
  input logic            alu_out_valid_i,
  input logic            alu_out_ready_o,
  input logic            wr_req_o,
  input logic            wr_gnt_i,
  input logic [DW-1:0]   result_o
);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_i && !busy_o && !kill_i) |=> busy_o);

  // R4
  no_rdreq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (rd_req_o == '0));

  // R3
  rdreq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(rd_req_o & rd_gnt_i)) && !kill_i) |=>
      ((rd_req_o & $past(rd_req_o & rd_gnt_i)) == '0));

  // R6
  ivld_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_in_valid_o && !alu_in_ready_i && !kill_i) |=> alu_in_valid_o);

  // R7
  ordy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_out_ready_o && alu_out_valid_i) |=> !alu_out_ready_o);

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shadow_n_i && !wr_req_o) |=> !wr_req_o);

  // R9
  retire_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req_o && wr_gnt_i) |=> (!busy_o && !wr_req_o));

  // R9
  result_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_req_o && wr_gnt_i) |-> (result_o == '0));

  // R10
  kill_clear_chk: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> (!busy_o && rd_req_o == '0 && !wr_req_o &&
                !alu_in_valid_o && !alu_out_ready_o));

endmodule

bind fu_hshake fu_hs_chk #(.NSRC(NSRC), .DW(DW)) u_hs_chk (.*);

// File: tb/fu_hshake_test.sv
`timescale 1ns/1ps
module fu_hshake_test;
  localparam int N  = 3;
  localparam int W  = 16;
  localparam int OPS = 60;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst = 1'b1, issue = 0, kill = 0, shadow_n = 1;
  logic [N-1:0]   rd_gnt = '0;
  logic [N*W-1:0] src = '0;
  logic           in_rdy = 0, out_vld = 0, wr_gnt = 0;
  logic [W-1:0]   alu_res = '0;
  logic           busy, ivld, ordy, wreq;
  logic [N-1:0]   rd_req;
  logic [N*W-1:0] opnd;
  logic [W-1:0]   result;

  fu_hshake #(.NSRC(N), .DW(W)) uut (
    .clk(clk), .rst(rst), .issue_i(issue), .kill_i(kill), .shadow_n_i(shadow_n),
    .busy_o(busy), .rd_req_o(rd_req), .rd_gnt_i(rd_gnt), .src_i(src),
    .alu_opnd_o(opnd), .alu_in_valid_o(ivld), .alu_in_ready_i(in_rdy),
    .alu_res_i(alu_res), .alu_out_valid_i(out_vld), .alu_out_ready_o(ordy),
    .wr_req_o(wreq), .wr_gnt_i(wr_gnt), .result_o(result));

  // behavioural reference
  bit             m_busy, m_ivld, m_ordy, m_have, m_wreq;
  bit [N-1:0]     m_req;
  bit [N*W-1:0]   m_opnd;
  bit [W-1:0]     m_hold;
  int             retired = 0;

  always @(posedge clk) begin
    bit [N-1:0] r0; bit iv0, or0, hv0, wq0;
    r0 = m_req; iv0 = m_ivld; or0 = m_ordy; hv0 = m_have; wq0 = m_wreq;
    if (rst) begin
      m_busy = 0; m_req = '0; m_ivld = 0; m_ordy = 0; m_have = 0; m_wreq = 0;
      m_opnd = '0; m_hold = '0;
    end else if (kill) begin
      m_busy = 0; m_req = '0; m_ivld = 0; m_ordy = 0; m_have = 0; m_wreq = 0;
    end else if (!m_busy) begin
      if (issue) begin m_busy = 1; m_req = '1; end
    end else begin
      for (int i = 0; i < N; i++)
        if (r0[i] && rd_gnt[i]) begin
          m_opnd[i*W +: W] = src[i*W +: W];
          m_req[i] = 0;
        end
      if (r0 != 0 && m_req == 0) m_ivld = 1;
      if (iv0 && in_rdy) begin m_ivld = 0; m_ordy = 1; end
      if (or0 && out_vld) begin m_ordy = 0; m_have = 1; m_hold = alu_res; end
      if (hv0 && !wq0 && shadow_n) m_wreq = 1;
      if (wq0 && wr_gnt) begin m_wreq = 0; m_busy = 0; m_have = 0; retired++; end
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string tag, string what, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  bit k_prev = 0;

  task automatic compare_all();
    string tb;
    tb = rst ? "R1" : "R2";
    chk(tb, "busy", N*W'(busy), N*W'(m_busy));
    chk(rst ? "R1" : "R3", "rd_req", N*W'(rd_req), N*W'(m_req));
    if (!m_busy) chk("R4", "rd_req idle", N*W'(rd_req), '0);
    chk("R5", "operands", opnd, m_opnd);
    chk("R6", "alu_in_valid", N*W'(ivld), N*W'(m_ivld));
    chk("R7", "alu_out_ready", N*W'(ordy), N*W'(m_ordy));
    chk("R8", "wr_req", N*W'(wreq), N*W'(m_wreq));
    chk("R9", "result", N*W'(result), (m_wreq && wr_gnt) ? N*W'(m_hold) : '0);
    if (k_prev) begin
      chk("R10", "after kill", N*W'({busy, rd_req, wreq, ivld, ordy}), '0);
    end
  endtask

  // dummy ALU state
  bit         pend = 0, f_acc = 0, f_take = 0;
  int         cnt = 0;
  bit [W-1:0] sum_q = '0, sum_n = '0;
  int         issued = 0, cyc = 0, gap = 0;
  bit         done = 0;

  initial begin
    repeat (3) begin @(negedge clk); #1; compare_all(); end
    rst = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      // dummy ALU reacts to handshakes of the previous edge
      if (f_acc) begin pend = 1; cnt = $urandom % 5; sum_q = sum_n; out_vld = 0; end
      else if (f_take) out_vld = 0;
      if (pend && !out_vld) begin
        if (cnt == 0) begin out_vld = 1; alu_res = sum_q; pend = 0; end
        else cnt--;
      end
      in_rdy = ($urandom % 2) == 0;
      // stimulus
      issue = 0; kill = 0; rd_gnt = '0; wr_gnt = 0;
      if (!m_busy && issued < OPS) begin
        if (gap > 0) gap--;
        else begin
          issue = 1; issued++; gap = $urandom % 3;
          for (int i = 0; i < N; i++) src[i*W +: W] = W'($urandom);
          if (issued > 30 && ($urandom % 4) == 0) begin kill = 1; issued--; end // R10 issue dropped
        end
      end
      for (int i = 0; i < N; i++)
        if (rd_req[i] && (issued <= 10 || ($urandom % 3) == 0)) rd_gnt[i] = 1;
      shadow_n = (issued <= 10) ? 1'b1 : (($urandom % 3) != 0);
      if (wreq && ($urandom % 3) == 0) wr_gnt = 1;
      if (issued > 30 && m_busy && ($urandom % 12) == 0) kill = 1;
      #1;
      compare_all();
      k_prev = kill;
      f_acc  = ivld && in_rdy;
      f_take = out_vld && ordy;
      if (f_acc) sum_n = opnd[0 +: W] + opnd[W +: W] + opnd[2*W +: W];
      if (issued >= OPS && !m_busy) done = 1;
      if (cyc > LIMIT) begin
        n_bad++;
        $display("FAIL watchdog: run hung, actual=%0d expected=%0d issues", issued, OPS);
        done = 1;
      end
    end
    if (retired < 10) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 retirements actual=%0d expected>=10", retired);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule